// File: doc/BRIEF.md
# Indexed Block-Transfer SMBus Register Target

This block is a target on a two-wire SMBus segment. It gives a host access to a bank of 8-bit configuration registers through indexed block transfers. The block oversamples both bus lines with the system clock. It finds start and stop conditions, shifts address and data bytes in and out, and drives the data line low only when it acknowledges a byte or sends a read bit. The line is open-drain, so the block never drives it high. The register contents are brought out as a flat vector, so the rest of the chip can use the configuration.

In a write, the host sends the target address with the write bit, a starting index and a byte count. The data bytes follow, and they are stored at ascending indices. A read begins in the same way with an index write. After a repeated start the host sends the address with the read bit. The target then sends a count byte, taken from a writable count register, and after it the register bytes from the index upward. The target keeps sending until the host withholds its acknowledge.

The 7-bit target address is picked from two choices by a select input. The block samples this input once, on the first clock after reset. Two identity bytes are read-only. A few locations are reserved, and they read as zero.

Top module: `smbus_blockreg_target`

## Requirements
- R1: The target address is 0x68 when `addr_sel` is 0 on the first clock after reset, and 0x6A when it is 1. Later changes of `addr_sel` have no effect until the next reset. On the bus the address byte is the address shifted left by one, with the read/write bit in bit 0 (0 = write, 1 = read). A matching address is acknowledged by pulling SDA low during the ninth clock.
- R2: An address byte that does not match gets no acknowledge. The target then leaves SDA released for every clock until the next start condition.
- R3: A write transfer is address+W, index N, count X, then data. The data bytes are stored at N, N+1, and so on, and each byte is acknowledged. Register i appears on `cfg_q[8i+7:8i]`.
- R4: Once X data bytes have been accepted, any further data byte is not acknowledged and is not stored. The target then releases the bus.
- R5: A read transfer is address+W and index N, then a repeated start and address+R. The target first sends the count byte. That byte is the 5-bit count field in its low bits, with the upper bits zero. After it come the bytes N, N+1, and so on. Every byte is sent MSB first.
- R6: A host NACK after a read byte ends the read. SDA stays released for all later clocks until a start. A stop always returns the target to idle.
- R7: Register 5 reads 0x01 and register 6 reads 0x08. Both are read-only: writes to them are acknowledged and discarded.
- R8: Reserved registers 4, 8, 9 and 17 always read 0x00. Indices at or above the bank size (20) also read 0x00. Writes to all of these are acknowledged and discarded.
- R9: Register 7 holds the 5-bit read count in bits 4:0, with reset value 8. Bits 7:5 always read 0.
- R10: After reset SDA is released. The target changes its SDA drive only while SCL is low. It drives SDA only during the acknowledge slot of a byte it accepts, or during the bits of a byte it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 1 | Target address select, sampled once after reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 = pull SDA low; 0 = release |
| cfg_q | output | 160 | All register bytes, register i at bits 8i+7:8i |

## Verification
The bench sends one data byte more than the announced count. A target that ignored the count would acknowledge that byte and overwrite the next register. The bench also changes `addr_sel` after reset. It then writes an odd value into the count register, whose low five bits must come back as the first read byte: a target with an unlatched select would change address, and a target with an unmasked count register would return the upper bits. Reads cross the end of the bank, and they clock extra bits after the host NACK. A target that wrapped its index or kept driving after the NACK would corrupt the line in both cases.

// File: rtl/smbus_blockreg_pkg.sv
package smbus_blockreg_pkg;
   localparam int BYTE_W  = 8;
   localparam int SADDR_W = 7;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RX_ACK,
      PH_TX,
      PH_TX_ACK
   } phase_e;

   typedef enum logic [1:0] {
      RL_ADDR,
      RL_INDEX,
      RL_COUNT,
      RL_DATA
   } role_e;
endpackage

// File: rtl/smbus_line_sync.sv
module smbus_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smbus_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/smbus_xfer_engine.sv
module smbus_xfer_engine
   import smbus_blockreg_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_s,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               start_det,
   input  logic               stop_det,
   input  logic [SADDR_W-1:0] my_addr,
   input  logic [BYTE_W-1:0]  cnt_byte,
   input  logic [BYTE_W-1:0]  rd_data,
   output logic [BYTE_W-1:0]  idx,
   output logic               wr_en,
   output logic [BYTE_W-1:0]  wr_data,
   output logic               sda_drive
);
   phase_e            phase_q;
   role_e             role_q;
   logic [3:0]        bitcnt_q;
   logic [2:0]        txcnt_q;
   logic [BYTE_W-1:0] sh_q, txsh_q, idx_q, remain_q;
   logic              rd_mode_q, drive_q;
   logic              byte_done, ack_c;

   assign byte_done = (phase_q == PH_RX) && (bitcnt_q == 4'd8) && scl_fall
                      && !start_det && !stop_det;

   always_comb begin
      unique case (role_q)
         RL_ADDR:  ack_c = (sh_q[BYTE_W-1:1] == my_addr);
         RL_INDEX: ack_c = 1'b1;
         RL_COUNT: ack_c = 1'b1;
         RL_DATA:  ack_c = (remain_q != '0);
      endcase
   end

   assign wr_en     = byte_done && (role_q == RL_DATA) && (remain_q != '0);
   assign wr_data   = sh_q;
   assign idx       = idx_q;
   assign sda_drive = drive_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         role_q    <= RL_ADDR;
         bitcnt_q  <= '0;
         txcnt_q   <= '0;
         sh_q      <= '0;
         txsh_q    <= '0;
         idx_q     <= '0;
         remain_q  <= '0;
         rd_mode_q <= 1'b0;
         drive_q   <= 1'b0;
      end else if (start_det) begin
         phase_q  <= PH_RX;
         role_q   <= RL_ADDR;
         bitcnt_q <= '0;
         drive_q  <= 1'b0;
      end else if (stop_det) begin
         phase_q <= PH_IDLE;
         drive_q <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_IDLE: ;
            PH_RX: begin
               if (scl_rise && bitcnt_q != 4'd8) begin
                  sh_q     <= {sh_q[BYTE_W-2:0], sda_s};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end
               if (byte_done) begin
                  bitcnt_q <= '0;
                  if (ack_c) begin
                     phase_q <= PH_RX_ACK;
                     drive_q <= 1'b1;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
                  unique case (role_q)
                     RL_ADDR: begin
                        rd_mode_q <= sh_q[0];
                        role_q    <= RL_INDEX;
                     end
                     RL_INDEX: begin
                        idx_q  <= sh_q;
                        role_q <= RL_COUNT;
                     end
                     RL_COUNT: begin
                        remain_q <= sh_q;
                        role_q   <= RL_DATA;
                     end
                     RL_DATA: begin
                        if (ack_c) begin
                           remain_q <= remain_q - 8'd1;
                           idx_q    <= idx_q + 8'd1;
                        end
                     end
                  endcase
               end
            end
            PH_RX_ACK: begin
               if (scl_fall) begin
                  if (rd_mode_q) begin
                     txsh_q  <= cnt_byte;
                     txcnt_q <= '0;
                     drive_q <= ~cnt_byte[BYTE_W-1];
                     phase_q <= PH_TX;
                  end else begin
                     drive_q <= 1'b0;
                     phase_q <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (scl_fall) begin
                  if (txcnt_q == 3'd7) begin
                     phase_q <= PH_TX_ACK;
                     drive_q <= 1'b0;
                  end else begin
                     txsh_q  <= {txsh_q[BYTE_W-2:0], 1'b0};
                     drive_q <= ~txsh_q[BYTE_W-2];
                     txcnt_q <= txcnt_q + 3'd1;
                  end
               end
            end
            PH_TX_ACK: begin
               if (scl_rise && sda_s) begin
                  phase_q <= PH_IDLE;
               end else if (scl_fall) begin
                  txsh_q  <= rd_data;
                  drive_q <= ~rd_data[BYTE_W-1];
                  idx_q   <= idx_q + 8'd1;
                  txcnt_q <= '0;
                  phase_q <= PH_TX;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && !scl_rise && !start_det && !stop_det) |-> $stable(drive_q)); // R10
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !drive_q); // R2
   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (phase_q == PH_IDLE)); // R6
   AST_BITCNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt_q <= 4'd8); // R3
   AST_NO_ACK_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && role_q == RL_DATA && remain_q == '0) |=> !drive_q); // R4
   AST_TX_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_TX) |-> rd_mode_q); // R5
endmodule

// File: rtl/smbus_cfg_bank.sv
module smbus_cfg_bank
   import smbus_blockreg_pkg::*;
#(
   parameter int            NREG      = 20,
   parameter logic [255:0]  RO_MASK   = 256'h60,
   parameter logic [255:0]  RSVD_MASK = 256'h20310,
   parameter int            VID_IDX   = 5,
   parameter logic [7:0]    VID_BYTE  = 8'h01,
   parameter int            DID_IDX   = 6,
   parameter logic [7:0]    DID_BYTE  = 8'h08,
   parameter int            CNT_IDX   = 7,
   parameter int            CNT_BITS  = 5,
   parameter int            CNT_RST   = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [BYTE_W-1:0]      idx,
   input  logic                   wr_en,
   input  logic [BYTE_W-1:0]      wr_data,
   output logic [BYTE_W-1:0]      rd_data,
   output logic [BYTE_W-1:0]      cnt_byte,
   output logic [NREG*BYTE_W-1:0] cfg_q
);
   localparam int AW = (NREG > 1) ? $clog2(NREG) : 1;

   logic [NREG-1:0][BYTE_W-1:0] regs;
   logic                        in_range;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [BYTE_W-1:0] MY_IDX = BYTE_W'(i);
      if (RO_MASK[i]) begin : g_ro
         if (i == VID_IDX) begin : g_vid
            assign regs[i] = VID_BYTE;
         end else if (i == DID_IDX) begin : g_did
            assign regs[i] = DID_BYTE;
         end else begin : g_zero
            assign regs[i] = '0;
         end
      end else if (RSVD_MASK[i]) begin : g_rsvd
         assign regs[i] = '0;
      end else if (i == CNT_IDX) begin : g_cnt
         logic [CNT_BITS-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= CNT_BITS'(CNT_RST);
            else if (wr_en && idx == MY_IDX)   q <= wr_data[CNT_BITS-1:0];
         end
         assign regs[i] = {{(BYTE_W-CNT_BITS){1'b0}}, q};
      end else begin : g_rw
         logic [BYTE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= '0;
            else if (wr_en && idx == MY_IDX)   q <= wr_data;
         end
         assign regs[i] = q;
      end
   end

   assign in_range = ({1'b0, idx} < (BYTE_W+1)'(NREG));
   assign rd_data  = in_range ? regs[idx[AW-1:0]] : '0;
   assign cnt_byte = regs[CNT_IDX];
   assign cfg_q    = regs;
endmodule

// File: rtl/smbus_blockreg_target.sv
module smbus_blockreg_target
   import smbus_blockreg_pkg::*;
#(
   parameter int            NREG        = 20,
   parameter int            SYNC_STAGES = 2,
   parameter logic [6:0]    ADDR_LO     = 7'h68,
   parameter logic [6:0]    ADDR_HI     = 7'h6A,
   parameter logic [255:0]  RO_MASK     = 256'h60,
   parameter logic [255:0]  RSVD_MASK   = 256'h20310,
   parameter int            VID_IDX     = 5,
   parameter logic [7:0]    VID_BYTE    = 8'h01,
   parameter int            DID_IDX     = 6,
   parameter logic [7:0]    DID_BYTE    = 8'h08,
   parameter int            CNT_IDX     = 7,
   parameter int            CNT_BITS    = 5,
   parameter int            CNT_RST     = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   addr_sel,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   output logic [NREG*BYTE_W-1:0] cfg_q
);
   if (NREG < 8 || NREG > 256) begin : g_bad_nreg
      $error("smbus_blockreg_target: NREG out of range");
   end
   if (CNT_BITS < 1 || CNT_BITS >= BYTE_W) begin : g_bad_cnt
      $error("smbus_blockreg_target: CNT_BITS must be 1..7");
   end
   if (CNT_IDX >= NREG || VID_IDX >= NREG || DID_IDX >= NREG) begin : g_bad_idx
      $error("smbus_blockreg_target: special index beyond bank");
   end
   if (ADDR_LO == ADDR_HI) begin : g_bad_addr
      $error("smbus_blockreg_target: address choices must differ");
   end

   logic                 sel_taken, sel_q;
   logic [SADDR_W-1:0]   my_addr;
   logic                 scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [BYTE_W-1:0]    idx, wr_data, rd_data, cnt_byte;
   logic                 wr_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_taken <= 1'b0;
         sel_q     <= 1'b0;
      end else if (!sel_taken) begin
         sel_taken <= 1'b1;
         sel_q     <= addr_sel;
      end
   end

   assign my_addr = sel_q ? ADDR_HI : ADDR_LO;

   smbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbus_xfer_engine u_eng (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .my_addr(my_addr), .cnt_byte(cnt_byte), .rd_data(rd_data),
      .idx(idx), .wr_en(wr_en), .wr_data(wr_data), .sda_drive(sda_oe)
   );

   smbus_cfg_bank #(
      .NREG(NREG), .RO_MASK(RO_MASK), .RSVD_MASK(RSVD_MASK),
      .VID_IDX(VID_IDX), .VID_BYTE(VID_BYTE), .DID_IDX(DID_IDX), .DID_BYTE(DID_BYTE),
      .CNT_IDX(CNT_IDX), .CNT_BITS(CNT_BITS), .CNT_RST(CNT_RST)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .idx(idx), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cnt_byte(cnt_byte), .cfg_q(cfg_q)
   );

   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel_taken) && sel_taken) |-> $stable(sel_q)); // R1
endmodule

// File: tb/smbus_blockreg_target_test.sv
module smbus_blockreg_target_test;
   localparam int Q = 8;

   typedef struct {
      string tag;
      int    val;
   } item_t;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic         rst_n = 1'b0;
   logic         addr_sel = 1'b0;
   logic         scl_h = 1'b1;
   logic         sda_h = 1'b1;
   logic         sda_line;
   logic         sda_oe;
   logic [159:0] cfg_q;

   int checks = 0;
   int failures = 0;
   int oe_hits = 0;
   item_t exp_q[$];
   int    obs_q[$];

   assign sda_line = sda_h & ~sda_oe;

   smbus_blockreg_target uut (
      .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
      .scl_i(scl_h), .sda_i(sda_line), .sda_oe(sda_oe), .cfg_q(cfg_q)
   );

   always @(posedge clk) if (sda_oe) oe_hits++;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   function automatic int cfg_byte(input int i);
      return int'(cfg_q[i*8 +: 8]);
   endfunction

   // scoreboard monitor: compares each observed bus item with the next expected one
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0) begin
            int    o;
            item_t e;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
               chk("unexpected bus item", o, -1);
            end else begin
               e = exp_q.pop_front();
               chk(e.tag, o, e.val);
            end
         end
      end
   end

   task automatic expect_item(input string tag, input int v);
      item_t it;
      it.tag = tag;
      it.val = v;
      exp_q.push_back(it);
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic r);
      sda_h = b;   wait_q();
      scl_h = 1'b1; wait_q();
      r = sda_line; wait_q();
      scl_h = 1'b0; wait_q();
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wait_q();
      scl_h = 1'b1; wait_q();
      sda_h = 1'b0; wait_q();
      scl_h = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wait_q();
      scl_h = 1'b1; wait_q();
      sda_h = 1'b1; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) bit_io(b[i], r);
      bit_io(1'b1, r);
      obs_q.push_back(int'(r));
   endtask

   task automatic recv_byte(input logic nack);
      logic [7:0] v;
      logic r;
      for (int i = 7; i >= 0; i--) begin
         bit_io(1'b1, r);
         v[i] = r;
      end
      bit_io(nack, r);
      obs_q.push_back(int'(v));
   endtask

   task automatic do_reset(input logic sel);
      rst_n = 1'b0; addr_sel = sel; scl_h = 1'b1; sda_h = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic drain();
      while (obs_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int snap;
      do_reset(1'b0);
      chk("R10 reset releases SDA", int'(sda_oe), 0);
      chk("R7 reg5 reset", cfg_byte(5), 8'h01);
      chk("R7 reg6 reset", cfg_byte(6), 8'h08);
      chk("R9 reg7 reset", cfg_byte(7), 8'h08);
      chk("R3 reg0 reset", cfg_byte(0), 8'h00);

      // block write of three bytes at index 0
      bus_start();
      expect_item("R1 ack addr 0x68 write", 0); send_byte(8'hD0);
      expect_item("R3 ack index", 0);           send_byte(8'h00);
      expect_item("R3 ack count", 0);           send_byte(8'h03);
      expect_item("R3 ack data0", 0);           send_byte(8'hA5);
      expect_item("R3 ack data1", 0);           send_byte(8'h5A);
      expect_item("R3 ack data2", 0);           send_byte(8'h3C);
      bus_stop(); drain();
      chk("R3 reg0", cfg_byte(0), 8'hA5);
      chk("R3 reg1", cfg_byte(1), 8'h5A);
      chk("R3 reg2", cfg_byte(2), 8'h3C);

      // other address: ignored
      snap = oe_hits;
      bus_start();
      expect_item("R2 no ack foreign address", 1); send_byte(8'hD4);
      expect_item("R2 ignored byte", 1);           send_byte(8'h00);
      bus_stop(); drain();
      chk("R2 SDA never driven", oe_hits - snap, 0);

      // select changed after reset: address must stay 0x68
      addr_sel = 1'b1;
      bus_start();
      expect_item("R1 latched address still acks", 0); send_byte(8'hD0);
      expect_item("R3 ack index", 0);                  send_byte(8'h03);
      expect_item("R3 ack count", 0);                  send_byte(8'h01);
      expect_item("R3 ack data", 0);                   send_byte(8'h77);
      bus_stop(); drain();
      chk("R1 write under latched address", cfg_byte(3), 8'h77);

      // writes across reserved, read-only and count register
      bus_start();
      expect_item("R8 ack addr", 0);          send_byte(8'hD0);
      expect_item("R8 ack index", 0);         send_byte(8'h04);
      expect_item("R8 ack count", 0);         send_byte(8'h04);
      expect_item("R8 ack reserved write", 0); send_byte(8'h11);
      expect_item("R7 ack ro write5", 0);     send_byte(8'h22);
      expect_item("R7 ack ro write6", 0);     send_byte(8'h33);
      expect_item("R9 ack count write", 0);   send_byte(8'h44);
      bus_stop(); drain();
      chk("R8 reserved reg4 stays 0", cfg_byte(4), 8'h00);
      chk("R7 reg5 unchanged", cfg_byte(5), 8'h01);
      chk("R7 reg6 unchanged", cfg_byte(6), 8'h08);
      chk("R9 reg7 masked to 5 bits", cfg_byte(7), 8'h04);

      // byte beyond the count
      bus_start();
      expect_item("R4 ack addr", 0);          send_byte(8'hD0);
      expect_item("R4 ack index", 0);         send_byte(8'h0A);
      expect_item("R4 ack count", 0);         send_byte(8'h01);
      expect_item("R4 ack counted byte", 0);  send_byte(8'h99);
      expect_item("R4 nack excess byte", 1);  send_byte(8'h88);
      bus_stop(); drain();
      chk("R4 counted byte stored", cfg_byte(10), 8'h99);
      chk("R4 excess byte discarded", cfg_byte(11), 8'h00);
      chk("R4 bus released", int'(sda_oe), 0);

      // block read from index 0
      bus_start();
      expect_item("R5 ack addr w", 0);  send_byte(8'hD0);
      expect_item("R5 ack index", 0);   send_byte(8'h00);
      bus_start();
      expect_item("R5 ack addr r", 0);  send_byte(8'hD1);
      expect_item("R5 count byte", 8'h04); recv_byte(1'b0);
      expect_item("R5 data0", 8'hA5);   recv_byte(1'b0);
      expect_item("R5 data1", 8'h5A);   recv_byte(1'b0);
      expect_item("R5 data2", 8'h3C);   recv_byte(1'b0);
      expect_item("R5 data3", 8'h77);   recv_byte(1'b0);
      expect_item("R8 reserved reads 0", 8'h00); recv_byte(1'b1);
      drain();
      chk("R6 released after nack", int'(sda_oe), 0);
      snap = oe_hits;
      expect_item("R6 line idle after nack", 8'hFF); recv_byte(1'b1);
      bus_stop(); drain();
      chk("R6 no drive after nack", oe_hits - snap, 0);

      // fill top of bank, full count value
      bus_start();
      expect_item("R3 ack addr", 0);  send_byte(8'hD0);
      expect_item("R3 ack index", 0); send_byte(8'h12);
      expect_item("R3 ack count", 0); send_byte(8'h02);
      expect_item("R3 ack d18", 0);   send_byte(8'h5E);
      expect_item("R3 ack d19", 0);   send_byte(8'hC3);
      bus_stop();
      bus_start();
      expect_item("R9 ack addr", 0);  send_byte(8'hD0);
      expect_item("R9 ack index", 0); send_byte(8'h07);
      expect_item("R9 ack count", 0); send_byte(8'h01);
      expect_item("R9 ack value", 0); send_byte(8'hFF);
      bus_stop(); drain();
      chk("R9 upper bits read 0", cfg_byte(7), 8'h1F);
      chk("R3 reg18", cfg_byte(18), 8'h5E);

      // read across the end of the bank
      bus_start();
      expect_item("R5 ack addr w", 0);  send_byte(8'hD0);
      expect_item("R5 ack index", 0);   send_byte(8'h13);
      bus_start();
      expect_item("R5 ack addr r", 0);  send_byte(8'hD1);
      expect_item("R9 count byte 0x1F", 8'h1F); recv_byte(1'b0);
      expect_item("R5 data19", 8'hC3);  recv_byte(1'b0);
      expect_item("R8 beyond bank reads 0", 8'h00); recv_byte(1'b1);
      bus_stop(); drain();

      // reset with the other select value
      do_reset(1'b1);
      chk("R3 reg0 back to reset", cfg_byte(0), 8'h00);
      bus_start();
      expect_item("R1 old address refused", 1); send_byte(8'hD0);
      bus_stop();
      bus_start();
      expect_item("R1 ack addr 0x6A", 0); send_byte(8'hD4);
      expect_item("R1 ack index", 0);     send_byte(8'h00);
      expect_item("R1 ack count", 0);     send_byte(8'h01);
      expect_item("R1 ack data", 0);      send_byte(8'h42);
      bus_stop(); drain();
      chk("R1 write at 0x6A", cfg_byte(0), 8'h42);

      chk("scoreboard leftover expected items", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule